// File: doc/BRIEF.md
# Serial Port Register Front End with Banked Divisor

This block is the software-visible register file of a 16550-compatible serial port. A 32-bit bus with byte addresses and one register per word reads and writes the port's control registers. Bit 7 of the line control register switches the two lowest slots from the data and interrupt-enable registers to the two bytes of the baud divisor. The transmit shifter, the receiver, the baud generator and the FIFO storage sit outside the block. They talk to it through level status inputs, one-cycle event pulses, push/pop/clear strobes and configuration outputs.

On a read, the block builds the line status word from registered FIFO and shifter status and from sticky error flags. It also builds the interrupt identification word from a fixed priority among the enabled sources. A vendor status word reports both FIFO occupancy counts, both idle flags and two sticky FIFO misuse flags, and reading that word clears the sticky flags. Read data is combinational from the current address. Side effects of a read (a receive pop, clearing sticky flags) take effect at the clock edge that ends the read cycle.

Top module: `uart_regfile`

## Requirements
- R1: After reset every register reads zero, except line status, which reads 0x260 (holding empty, shift empty and RX FIFO empty) while those status inputs are high. Interrupt identification reads 0x01, `divisor_o` is 0 and `irq_o` is low.
- R2: While line control bit 7 is set, word 0 reads and writes the divisor low byte and word 1 the divisor high byte. `divisor_o` is {high, low} and changes only on such writes.
- R3: While line control bit 7 is clear, a write to word 0 pulses `tx_push_o` for that cycle with `tx_data_o` equal to write data bits 7:0. A read of word 0 returns `rx_data_i` and pulses `rx_pop_o`. Neither access alters the divisor.
- R4: Interrupt enable (word 1, 6 bits) reads back what was written. Line control (word 3), modem control (4), scratch (7), inversion control (8), RX FIFO config (9) and modem interrupt enable (10) keep 8 bits each. Unused upper bits read 0. Inversion bits 3:0 drive `inv_o`, which inverts RXD, TXD, CTS and RTS respectively.
- R5: A write to word 2 pulses `tx_clr_o` for that cycle when bit 2 is set and `rx_clr_o` when bit 1 is set. Neither bit is stored. The other bits are held and appear on `fcr_o`, where bit 0 is FIFO enable.
- R6: Line status (word 5) bit 0 is data ready (RX FIFO not empty). Bit 5 is holding empty (`tx_empty_i`), bit 6 is shift empty (`tx_empty_i` and `shift_empty_i`), bit 7 is FIFO error, bit 8 is TX full and bit 9 is RX empty. Each bit is registered, so it shows the inputs one clock earlier.
- R7: Line status bits 1 to 4 (overrun, parity, framing, break) are set by pulses on their error inputs and hold until line status is read. A pulse in the same cycle as that read survives the clear.
- R8: Vendor status (word 11) holds the TX FIFO count in bits 29:24 and the RX FIFO count in bits 21:16. Bit 3 is a sticky TX overrun and bit 2 a sticky RX underrun, both cleared by reading word 11, with a set in the same cycle winning. Bit 1 is RX idle and bit 0 is TX idle.
- R9: Interrupt identification (word 2 read) has bit 0 low while any enabled source is pending, and `irq_o` follows that pending state. Bits 7:6 read 01 when FIFO enable is stored and 00 otherwise.
- R10: Priority, highest first, with identification codes in bits 3:0: line error 0x6 (any of line status bits 1 to 4), received data 0x4 (`rx_trig_i`), RX timeout 0xC, holding empty 0x2, modem status 0x0 (any of modem status bits 3:0), end of received data 0xE. The sources are gated by enable bits 2, 0, 4, 1, 3 and 5 respectively.
- R11: Reads of words 12 to 14 return zero and writes there have no effect. Writes to line status, modem status, vendor status and word 15 change nothing.
- R12: Word 6 returns `msr_i` and word 15 returns `aux_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for current address |
| tx_push_o | output | 1 | Push byte to TX FIFO |
| tx_data_o | output | 8 | Byte to push |
| rx_pop_o | output | 1 | Pop byte from RX FIFO |
| tx_clr_o | output | 1 | Clear TX FIFO |
| rx_clr_o | output | 1 | Clear RX FIFO |
| rx_data_i | input | 8 | Head byte of RX FIFO |
| rx_empty_i | input | 1 | RX FIFO empty |
| tx_empty_i | input | 1 | TX FIFO empty |
| shift_empty_i | input | 1 | TX shifter empty |
| tx_full_i | input | 1 | TX FIFO full |
| rx_fifo_err_i | input | 1 | Error byte present in RX FIFO |
| err_ovr_i | input | 1 | Overrun event pulse |
| err_par_i | input | 1 | Parity error event pulse |
| err_frm_i | input | 1 | Framing error event pulse |
| err_brk_i | input | 1 | Break event pulse |
| rx_trig_i | input | 1 | RX FIFO at trigger level |
| rx_tmo_i | input | 1 | RX character timeout |
| eord_i | input | 1 | End of received data |
| msr_i | input | 8 | Modem status, bits 3:0 deltas |
| aux_i | input | 8 | Auxiliary status word |
| tx_cnt_i | input | 6 | TX FIFO occupancy |
| rx_cnt_i | input | 6 | RX FIFO occupancy |
| tx_ovr_i | input | 1 | Write to full TX FIFO event |
| rx_udr_i | input | 1 | Read of empty RX FIFO event |
| rx_idle_i | input | 1 | Receiver idle |
| tx_idle_i | input | 1 | Transmitter idle |
| divisor_o | output | 16 | Baud divisor |
| lcr_o | output | 8 | Line control |
| mcr_o | output | 8 | Modem control |
| fcr_o | output | 8 | Stored FIFO control |
| inv_o | output | 4 | Invert RXD, TXD, CTS, RTS |
| rxcfg_o | output | 8 | RX FIFO config |
| mie_o | output | 8 | Modem interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that error and FIFO misuse inputs are single events aligned to the clock. They also assume that `bus_wr` and `bus_rd` are never raised together. The stimulus drives every input at the falling edge, raises one strobe per access and leaves an idle cycle between accesses. It holds status levels for at least one rising edge before it reads anything that depends on them. Random interrupt-source patterns leave the error inputs quiet, so the sticky flags stay clear. The line error source is exercised only by directed cases.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

    typedef enum logic [3:0] {
        REG_NONE, REG_DATA, REG_DLL, REG_IER, REG_DLH, REG_IIR_FCR,
        REG_LCR, REG_MCR, REG_LSR, REG_MSR, REG_SPR, REG_INV,
        REG_RXCFG, REG_MIE, REG_VSTAT, REG_AUX
    } reg_id_e;

    localparam int LSR_W      = 10;
    localparam logic [LSR_W-1:0] LSR_RESET = 10'h260;
    localparam int IER_W      = 6;
    localparam int NSRC       = 6;
    localparam int TXC_LSB    = 24;
    localparam int RXC_LSB    = 16;

    // interrupt codes in priority order, index 0 highest
    localparam logic [3:0] IRQ_CODE [NSRC] = '{4'h6, 4'h4, 4'hC, 4'h2, 4'h0, 4'hE};
    localparam logic [3:0] IRQ_NONE = 4'h1;

    typedef struct packed {
        logic [15:0]      div;
        logic [IER_W-1:0] ier;
        logic [7:0]       fcr;
        logic [7:0]       lcr;
        logic [7:0]       mcr;
        logic [7:0]       spr;
        logic [7:0]       inv;
        logic [7:0]       rxcfg;
        logic [7:0]       mie;
        logic [LSR_W-1:0] lsr;
    } regs_t;

endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dlab_i,
    output reg_id_e           id_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_byte;

    assign word        = addr_i[ADDR_W-1:2];
    assign unused_byte = addr_i[1:0];

    always_comb begin
        case (word)
            WORD_W'(0):  id_o = dlab_i ? REG_DLL : REG_DATA;
            WORD_W'(1):  id_o = dlab_i ? REG_DLH : REG_IER;
            WORD_W'(2):  id_o = REG_IIR_FCR;
            WORD_W'(3):  id_o = REG_LCR;
            WORD_W'(4):  id_o = REG_MCR;
            WORD_W'(5):  id_o = REG_LSR;
            WORD_W'(6):  id_o = REG_MSR;
            WORD_W'(7):  id_o = REG_SPR;
            WORD_W'(8):  id_o = REG_INV;
            WORD_W'(9):  id_o = REG_RXCFG;
            WORD_W'(10): id_o = REG_MIE;
            WORD_W'(11): id_o = REG_VSTAT;
            WORD_W'(15): id_o = REG_AUX;
            default:     id_o = REG_NONE;
        endcase
    end

endmodule

// File: rtl/uart_sticky.sv
module uart_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = clr_i ? set_i : (flag_q | set_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign q_o = flag_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);                      // R7
        AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i) |=> q_o[i]);            // R8
    end

endmodule

// File: rtl/uart_irq_pri.sv
module uart_irq_pri
    import uart_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IER_W-1:0] ier_i,
    input  logic             ls_i,
    input  logic             rx_i,
    input  logic             tmo_i,
    input  logic             thre_i,
    input  logic             msr_i,
    input  logic             eord_i,
    output logic [3:0]       id_o,
    output logic             pend_o
);
    logic [NSRC-1:0] src, grant;
    logic            found;

    always_comb begin
        src   = {eord_i & ier_i[5], msr_i & ier_i[3], thre_i & ier_i[1],
                 tmo_i & ier_i[4], rx_i & ier_i[0], ls_i & ier_i[2]};
        grant = '0;
        found = 1'b0;
        id_o  = IRQ_NONE;
        for (int i = 0; i < NSRC; i++) begin
            if (src[i] && !found) begin
                grant[i] = 1'b1;
                id_o     = IRQ_CODE[i];
                found    = 1'b1;
            end
        end
        pend_o = found;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                              // R10
    AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_i && ier_i[2]) |-> (id_o == 4'h6));        // R10

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_reg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_push_o,
    output logic [7:0]        tx_data_o,
    output logic              rx_pop_o,
    output logic              tx_clr_o,
    output logic              rx_clr_o,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_empty_i,
    input  logic              tx_empty_i,
    input  logic              shift_empty_i,
    input  logic              tx_full_i,
    input  logic              rx_fifo_err_i,
    input  logic              err_ovr_i,
    input  logic              err_par_i,
    input  logic              err_frm_i,
    input  logic              err_brk_i,
    input  logic              rx_trig_i,
    input  logic              rx_tmo_i,
    input  logic              eord_i,
    input  logic [7:0]        msr_i,
    input  logic [7:0]        aux_i,
    input  logic [CNT_W-1:0]  tx_cnt_i,
    input  logic [CNT_W-1:0]  rx_cnt_i,
    input  logic              tx_ovr_i,
    input  logic              rx_udr_i,
    input  logic              rx_idle_i,
    input  logic              tx_idle_i,
    output logic [15:0]       divisor_o,
    output logic [7:0]        lcr_o,
    output logic [7:0]        mcr_o,
    output logic [7:0]        fcr_o,
    output logic [3:0]        inv_o,
    output logic [7:0]        rxcfg_o,
    output logic [7:0]        mie_o,
    output logic              irq_o
);
    localparam logic [7:0] FCR_KEEP = 8'hF9;

    regs_t      st_d, st_q;
    reg_id_e    id;
    logic [3:0] lsr_err;
    logic [1:0] vs_sticky;
    logic [3:0] irq_id;
    logic       irq_pend;
    logic [LSR_W-1:0] lsr_full;
    logic [7:0] iir;
    logic [DATA_W-1:0] vstat;
    logic       unused_ok;

    assign unused_ok = ^bus_wdata[DATA_W-1:8];

    uart_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
        .addr_i (bus_addr),
        .dlab_i (st_q.lcr[7]),
        .id_o   (id)
    );

    uart_sticky #(.W(4)) i_lsr_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({err_brk_i, err_frm_i, err_par_i, err_ovr_i}),
        .clr_i (bus_rd && (id == REG_LSR)),
        .q_o   (lsr_err)
    );

    uart_sticky #(.W(2)) i_vs_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({tx_ovr_i, rx_udr_i}),
        .clr_i (bus_rd && (id == REG_VSTAT)),
        .q_o   (vs_sticky)
    );

    uart_irq_pri i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ier_i  (st_q.ier),
        .ls_i   (|lsr_err),
        .rx_i   (rx_trig_i),
        .tmo_i  (rx_tmo_i),
        .thre_i (st_q.lsr[5]),
        .msr_i  (|msr_i[3:0]),
        .eord_i (eord_i),
        .id_o   (irq_id),
        .pend_o (irq_pend)
    );

    // next-state
    always_comb begin
        st_d     = st_q;
        st_d.lsr = {rx_empty_i, tx_full_i, rx_fifo_err_i,
                    tx_empty_i & shift_empty_i, tx_empty_i, 4'b0000, ~rx_empty_i};
        if (bus_wr) begin
            case (id)
                REG_DLL:     st_d.div[7:0]  = bus_wdata[7:0];
                REG_DLH:     st_d.div[15:8] = bus_wdata[7:0];
                REG_IER:     st_d.ier       = bus_wdata[IER_W-1:0];
                REG_IIR_FCR: st_d.fcr       = bus_wdata[7:0] & FCR_KEEP;
                REG_LCR:     st_d.lcr       = bus_wdata[7:0];
                REG_MCR:     st_d.mcr       = bus_wdata[7:0];
                REG_SPR:     st_d.spr       = bus_wdata[7:0];
                REG_INV:     st_d.inv       = bus_wdata[7:0];
                REG_RXCFG:   st_d.rxcfg     = bus_wdata[7:0];
                REG_MIE:     st_d.mie       = bus_wdata[7:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lsr <= LSR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // read composition
    always_comb begin
        lsr_full = st_q.lsr | {5'b0, lsr_err, 1'b0};
        iir      = {st_q.fcr[0] ? 2'b01 : 2'b00, 2'b00, irq_id};
        vstat    = '0;
        vstat[TXC_LSB +: CNT_W] = tx_cnt_i;
        vstat[RXC_LSB +: CNT_W] = rx_cnt_i;
        vstat[3:0] = {vs_sticky, rx_idle_i, tx_idle_i};
        case (id)
            REG_DATA:    bus_rdata = DATA_W'(rx_data_i);
            REG_DLL:     bus_rdata = DATA_W'(st_q.div[7:0]);
            REG_DLH:     bus_rdata = DATA_W'(st_q.div[15:8]);
            REG_IER:     bus_rdata = DATA_W'(st_q.ier);
            REG_IIR_FCR: bus_rdata = DATA_W'(iir);
            REG_LCR:     bus_rdata = DATA_W'(st_q.lcr);
            REG_MCR:     bus_rdata = DATA_W'(st_q.mcr);
            REG_LSR:     bus_rdata = DATA_W'(lsr_full);
            REG_MSR:     bus_rdata = DATA_W'(msr_i);
            REG_SPR:     bus_rdata = DATA_W'(st_q.spr);
            REG_INV:     bus_rdata = DATA_W'(st_q.inv);
            REG_RXCFG:   bus_rdata = DATA_W'(st_q.rxcfg);
            REG_MIE:     bus_rdata = DATA_W'(st_q.mie);
            REG_VSTAT:   bus_rdata = vstat;
            REG_AUX:     bus_rdata = DATA_W'(aux_i);
            default:     bus_rdata = '0;
        endcase
    end

    assign tx_push_o = bus_wr && (id == REG_DATA);
    assign tx_data_o = bus_wdata[7:0];
    assign rx_pop_o  = bus_rd && (id == REG_DATA);
    assign tx_clr_o  = bus_wr && (id == REG_IIR_FCR) && bus_wdata[2];
    assign rx_clr_o  = bus_wr && (id == REG_IIR_FCR) && bus_wdata[1];
    assign divisor_o = st_q.div;
    assign lcr_o     = st_q.lcr;
    assign mcr_o     = st_q.mcr;
    assign fcr_o     = st_q.fcr;
    assign inv_o     = st_q.inv[3:0];
    assign rxcfg_o   = st_q.rxcfg;
    assign mie_o     = st_q.mie;
    assign irq_o     = irq_pend;

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (id == REG_DLL || id == REG_DLH)) |=> $stable(divisor_o)); // R2
    AST_POP_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop_o || tx_push_o) |-> !lcr_o[7]);                                // R3
    AST_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr_o || rx_clr_o) |-> (bus_wr && !bus_rd));                       // R5
    AST_FCR_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_o[2:1] == 2'b00);                                                  // R5
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bus_rdata[0] == 1'b0 || id != REG_IIR_FCR));                // R9

endmodule

// File: tb/test_uart_regfile.sv
module test_uart_regfile;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic tx_push_o, rx_pop_o, tx_clr_o, rx_clr_o, irq_o;
    logic [7:0] tx_data_o, lcr_o, mcr_o, fcr_o, rxcfg_o, mie_o;
    logic [15:0] divisor_o;
    logic [3:0] inv_o;
    logic [7:0] rx_data_i = '0, msr_i = '0, aux_i = '0;
    logic rx_empty_i = 1, tx_empty_i = 1, shift_empty_i = 1, tx_full_i = 0, rx_fifo_err_i = 0;
    logic err_ovr_i = 0, err_par_i = 0, err_frm_i = 0, err_brk_i = 0;
    logic rx_trig_i = 0, rx_tmo_i = 0, eord_i = 0;
    logic [5:0] tx_cnt_i = '0, rx_cnt_i = '0;
    logic tx_ovr_i = 0, rx_udr_i = 0, rx_idle_i = 0, tx_idle_i = 0;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] rv;
    logic s_push, s_pop, s_tclr, s_rclr;
    logic [7:0] s_tdata;

    always #5 clk = ~clk;

    uart_regfile i_uart_regfile (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        #4;
        s_push = tx_push_o; s_tdata = tx_data_o; s_tclr = tx_clr_o; s_rclr = rx_clr_o;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        #4;
        d = bus_rdata; s_pop = rx_pop_o;
        @(negedge clk);
        bus_rd = 0;
    endtask

    function automatic logic [7:0] exp_iir(logic [5:0] ier, logic fen, logic ls, logic rx,
                                           logic tmo, logic thre, logic ms, logic eo);
        logic [3:0] c;
        if (ls && ier[2]) c = 4'h6;
        else if (rx && ier[0]) c = 4'h4;
        else if (tmo && ier[4]) c = 4'hC;
        else if (thre && ier[1]) c = 4'h2;
        else if (ms && ier[3]) c = 4'h0;
        else if (eo && ier[5]) c = 4'hE;
        else c = 4'h1;
        return {fen ? 2'b01 : 2'b00, 2'b00, c};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset
        rd(6'h14, rv); chk("R1 lsr", rv, 32'h260);
        rd(6'h08, rv); chk("R1 iir", rv, 32'h01);
        rd(6'h04, rv); chk("R1 ier", rv, 0);
        rd(6'h0C, rv); chk("R1 lcr", rv, 0);
        chk("R1 div", {16'h0, divisor_o}, 0);
        chk("R1 irq", {31'h0, irq_o}, 0);

        // R2 divisor banking
        wr(6'h0C, 32'h83);
        wr(6'h00, 32'hFFFF_FF34);
        chk("R2 no push under latch", {31'h0, s_push}, 0);
        wr(6'h04, 32'h12);
        chk("R2 divisor_o", {16'h0, divisor_o}, 32'h1234);
        rd(6'h00, rv); chk("R2 dll read", rv, 32'h34);
        chk("R2 no pop under latch", {31'h0, s_pop}, 0);
        rd(6'h04, rv); chk("R2 dlh read", rv, 32'h12);
        wr(6'h0C, 32'h03);
        rd(6'h04, rv); chk("R2 ier visible again", rv, 0);

        // R3 data slot
        wr(6'h00, 32'h0000_ABC7);
        chk("R3 push", {31'h0, s_push}, 1);
        chk("R3 push data", {24'h0, s_tdata}, 32'hC7);
        chk("R3 divisor kept", {16'h0, divisor_o}, 32'h1234);
        rx_data_i = 8'hA5;
        rd(6'h00, rv); chk("R3 rx data", rv, 32'hA5);
        chk("R3 pop", {31'h0, s_pop}, 1);

        // R4 random readback of control registers
        for (int i = 0; i < 150; i++) begin
            logic [31:0] d; int sel; logic [5:0] a; logic [31:0] e;
            d = $urandom(); sel = $urandom_range(0, 6);
            case (sel)
                0: begin a = 6'h04; e = {26'h0, d[5:0]}; end
                1: begin a = 6'h0C; d[7] = 1'b0; e = {24'h0, d[7:0]}; end
                2: begin a = 6'h10; e = {24'h0, d[7:0]}; end
                3: begin a = 6'h1C; e = {24'h0, d[7:0]}; end
                4: begin a = 6'h20; e = {24'h0, d[7:0]}; end
                5: begin a = 6'h24; e = {24'h0, d[7:0]}; end
                default: begin a = 6'h28; e = {24'h0, d[7:0]}; end
            endcase
            wr(a, d);
            rd(a, rv); chk("R4 readback", rv, e);
        end
        wr(6'h20, 32'h0000_00A6);
        chk("R4 inv_o", {28'h0, inv_o}, 32'h6);
        wr(6'h0C, 32'h03);

        // R11 unmapped and read-only
        wr(6'h1C, 32'h5A);
        for (int w = 12; w < 15; w++) begin
            wr(6'(w * 4), 32'hFFFF_FFFF);
            rd(6'(w * 4), rv); chk("R11 unmapped reads zero", rv, 0);
        end
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h14, rv); chk("R11 lsr write ignored", rv, 32'h260);
        rd(6'h1C, rv); chk("R11 scratch untouched", rv, 32'h5A);

        // R12
        msr_i = 8'h9C; aux_i = 8'h3E;
        rd(6'h18, rv); chk("R12 msr", rv, 32'h9C);
        rd(6'h3C, rv); chk("R12 aux", rv, 32'h3E);
        msr_i = 0;

        // R5 FIFO control
        wr(6'h08, 32'hC7);
        chk("R5 tx clr", {31'h0, s_tclr}, 1);
        chk("R5 rx clr", {31'h0, s_rclr}, 1);
        chk("R5 fcr_o", {24'h0, fcr_o}, 32'hC1);
        wr(6'h08, 32'h01);
        chk("R5 no clr", {30'h0, s_tclr, s_rclr}, 0);

        // R6 line status composition
        @(negedge clk);
        tx_full_i = 1; rx_empty_i = 0; rx_fifo_err_i = 1; tx_empty_i = 0;
        rd(6'h14, rv); chk("R6 lsr pattern", rv, 32'h181);
        tx_full_i = 0; rx_empty_i = 1; rx_fifo_err_i = 0; tx_empty_i = 1; shift_empty_i = 0;
        rd(6'h14, rv); chk("R6 shift busy", rv, 32'h220);
        shift_empty_i = 1;

        // R7 sticky line errors
        @(negedge clk); err_par_i = 1; @(negedge clk); err_par_i = 0;
        rd(6'h14, rv); chk("R7 parity sticky", rv, 32'h264);
        rd(6'h14, rv); chk("R7 cleared by read", rv, 32'h260);
        @(negedge clk);
        bus_addr = 6'h14; bus_rd = 1; err_brk_i = 1;
        @(negedge clk); bus_rd = 0; err_brk_i = 0;
        rd(6'h14, rv); chk("R7 set wins over clear", rv, 32'h270);

        // R8 vendor status
        tx_cnt_i = 6'h2A; rx_cnt_i = 6'h15; rx_idle_i = 1; tx_idle_i = 0;
        @(negedge clk); tx_ovr_i = 1; @(negedge clk); tx_ovr_i = 0;
        rd(6'h2C, rv); chk("R8 vstat", rv, 32'h2A15_000A);
        @(negedge clk);
        bus_addr = 6'h2C; bus_rd = 1; rx_udr_i = 1;
        #4 rv = bus_rdata;
        @(negedge clk); bus_rd = 0; rx_udr_i = 0;
        chk("R8 cleared read", rv, 32'h2A15_0002);
        rd(6'h2C, rv); chk("R8 set wins", rv, 32'h2A15_0006);
        rd(6'h2C, rv); chk("R8 cleared", rv, 32'h2A15_0002);

        // R9/R10 directed priority
        rd(6'h14, rv);
        wr(6'h04, 32'h3F);
        rx_trig_i = 1;
        rd(6'h08, rv); chk("R10 rx over thre", rv, 32'h44);
        @(negedge clk); err_ovr_i = 1; @(negedge clk); err_ovr_i = 0;
        rd(6'h08, rv); chk("R10 line first", rv, 32'h46);
        rd(6'h14, rv);
        rd(6'h08, rv); chk("R10 after lsr read", rv, 32'h44);
        rx_trig_i = 0; rx_tmo_i = 1;
        rd(6'h08, rv); chk("R10 timeout", rv, 32'h4C);
        rx_tmo_i = 0;
        rd(6'h08, rv); chk("R10 thre", rv, 32'h42);
        chk("R9 irq high", {31'h0, irq_o}, 1);
        wr(6'h04, 32'h00);
        rd(6'h08, rv); chk("R9 masked", rv, 32'h41);
        chk("R9 irq low", {31'h0, irq_o}, 0);
        wr(6'h08, 32'h00);
        rd(6'h08, rv); chk("R9 legacy", rv, 32'h01);

        // R10 random sources
        for (int i = 0; i < 200; i++) begin
            logic [5:0] ier; logic fen; logic [7:0] e;
            ier = 6'($urandom()); fen = 1'($urandom());
            wr(6'h04, {26'h0, ier});
            wr(6'h08, {31'h0, fen});
            @(negedge clk);
            rx_trig_i = 1'($urandom()); rx_tmo_i = 1'($urandom());
            tx_empty_i = 1'($urandom()); eord_i = 1'($urandom());
            msr_i = 8'($urandom());
            e = exp_iir(ier, fen, 1'b0, rx_trig_i, rx_tmo_i, tx_empty_i, |msr_i[3:0], eord_i);
            rd(6'h08, rv); chk("R10 random iir", rv, {24'h0, e});
            chk("R9 random irq", {31'h0, irq_o}, {31'h0, ~e[0]});
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule